// File: doc/BRIEF.md
# Fast-Page-Mode DRAM Access Sequencer

This block turns single-word requests from a synchronous client into strobe sequences for a 36-bit, two-rank page-mode DRAM module. Each request carries a rank/row/column address, a read or write flag, a 4-bit lane enable and 36 bits of write data. The sequencer puts the row on an 11-bit shared address bus and lowers the row strobes of the selected rank. It then puts the column on the same bus and lowers one column strobe for each enabled 9-bit lane. A read returns the captured word with a one-cycle valid pulse.

A row stays open after an access. A later request to the same rank and row costs only a column cycle. A request to another row, an asserted refresh request, or the end of the allowed page-open window closes the page, and the full precharge time runs before the next activation. Every timing limit is given in nanoseconds as a parameter and converted to clock cycles, rounding up for minimums and down for maximums. Writes are always early writes: the write strobe is low before the column strobe falls, so the memory never drives the shared data pins during a write.

Top module: `dram_fpm_seq`

## Requirements
- R1: After reset, all four row strobes and all four column strobes are high, the write strobe is high, data output enable is low, `rd_valid_o` and `refresh_gnt_o` are low, and `req_ready_o` is high.
- R2: A request whose address bit 22 is 0 activates rank 0 by lowering `dram_ras_no[0]` and `dram_ras_no[2]`. When bit 22 is 1, rank 1 is activated by lowering `dram_ras_no[1]` and `dram_ras_no[3]`. The two ranks are never active together.
- R3: Column strobe `dram_cas_no[i]` goes low only when lane enable bit i is set. Lane i covers data bits 9i to 9i+8. A write leaves disabled lanes in memory unchanged.
- R4: The address bus carries the row (request bits 21:11) when the row strobes fall and the column (request bits 10:0) when a column strobe falls. The column stays stable while any column strobe is low.
- R5: During a write, the write strobe is low and data output enable is high while the column strobes are low, and the column low time is at least the write-to-column-rise setup. During a read, the write strobe is high and output enable is low while the column strobes are low.
- R6: A read produces exactly one `rd_valid_o` pulse. `rd_data_o` holds the stored word for enabled lanes and zero for disabled lanes. The data is sampled no earlier than the column access time after the column fall and the row access time after the row fall.
- R7: A request that hits the open rank and row is served without raising the row strobes. Column strobe high time is at least the column precharge, and column fall-to-fall is at least the page-mode cycle.
- R8: Row strobes stay low for at least the minimum row pulse and stay high for at least the row precharge. Consecutive row activations are at least the random cycle time apart.
- R9: While `refresh_i` is high no request is accepted and the open page closes. `refresh_gnt_o` is high only when every row strobe is high and the precharge time has elapsed.
- R10: Row strobes never stay low longer than the page-open limit. A continuous stream of page hits is broken by a close and reopen.
- R11: The first column strobe fall after a row fall lies between the minimum and maximum row-to-column delays.
- R12: Every column strobe low pulse lasts at least the minimum column pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request taken at this edge when valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 23 | {rank, row[10:0], column[10:0]} |
| req_lane_i | input | 4 | Lane enables, one per 9-bit lane |
| req_wdata_i | input | 36 | Write data |
| rd_valid_o | output | 1 | Read data valid pulse |
| rd_data_o | output | 36 | Read data, disabled lanes zero |
| refresh_i | input | 1 | Close the page and hold off requests |
| refresh_gnt_o | output | 1 | Page closed and precharged |
| dram_addr_o | output | 11 | Multiplexed row/column address |
| dram_ras_no | output | 4 | Row strobes, {rank1 high, rank0 high, rank1 low, rank0 low} |
| dram_cas_no | output | 4 | Column strobes, one per lane |
| dram_we_no | output | 1 | Write strobe, active low |
| dram_dq_o | output | 36 | Data to memory |
| dram_dq_oe_o | output | 1 | Drive enable for `dram_dq_o` |
| dram_dq_i | input | 36 | Data from memory |

## Verification
The embedded properties assume the client holds the request fields stable while `req_valid_i` is high and not yet accepted. They also assume every request enables at least one lane and that the clock-period parameter matches the real clock. The stimulus changes requests only at falling edges, waits for acceptance before moving on, and never issues an all-zero lane mask. It keeps `refresh_i` high until the grant has been seen. A memory model in the bench returns garbage until both access times have elapsed, so a read that samples too early shows up as a data mismatch.

// File: rtl/dram_fpm_pkg.sv
package dram_fpm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,  // row strobes high, precharging
    ST_RCD  = 2'd1,  // row strobes low, row on bus
    ST_CAS  = 2'd2,  // column strobes low
    ST_OPEN = 2'd3   // page open, column strobes high
  } fpm_st_e;

  function automatic int cdiv(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dram_fpm_ctrl.sv
module dram_fpm_ctrl
  import dram_fpm_pkg::*;
#(
  parameter int RP_C     = 3,
  parameter int RCD_C    = 1,
  parameter int CAS_WR_C = 1,
  parameter int CAS_RD_C = 1,
  parameter int RAC_C    = 3,
  parameter int RAS_C    = 3,
  parameter int CP_C     = 1,
  parameter int PAGE_C   = 5000,
  parameter int AGE_LIM  = 4993
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    req_valid_i,
  input  logic    req_hit_i,
  input  logic    refresh_i,
  input  logic    cur_wr_i,
  output logic    ready_o,
  output logic    accept_o,
  output logic    sample_o,
  output logic    gnt_o,
  output fpm_st_e st_o
);

  localparam int CNT_MAX = imax(imax(RP_C, RCD_C), imax(imax(CAS_WR_C, CAS_RD_C), CP_C));
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int AGE_W   = $clog2(PAGE_C + 1);

  fpm_st_e          st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [AGE_W-1:0] age_q, age_d;
  logic rp_done, rcd_done, cp_done, cas_done, close_pg;

  always_comb begin
    rp_done  = int'(cnt_q) >= RP_C - 1;
    rcd_done = int'(cnt_q) >= RCD_C - 1;
    cp_done  = int'(cnt_q) >= CP_C - 1;
    cas_done = cur_wr_i ? (int'(cnt_q) >= CAS_WR_C - 1)
                        : (int'(cnt_q) >= CAS_RD_C - 1 && int'(age_q) >= RAC_C - 1);
    ready_o  = !refresh_i &&
               ((st_q == ST_IDLE && rp_done) ||
                (st_q == ST_OPEN && cp_done && req_hit_i && int'(age_q) < AGE_LIM));
    accept_o = req_valid_i && ready_o;
    close_pg = st_q == ST_OPEN && cp_done && int'(age_q) >= RAS_C - 1 &&
               (refresh_i || int'(age_q) >= AGE_LIM || (req_valid_i && !req_hit_i));
    sample_o = st_q == ST_CAS && cas_done && !cur_wr_i;
    gnt_o    = st_q == ST_IDLE && rp_done && refresh_i;

    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (accept_o) st_d = ST_RCD;
      ST_RCD:  if (rcd_done) st_d = ST_CAS;
      ST_CAS:  if (cas_done) st_d = ST_OPEN;
      ST_OPEN: if (accept_o) st_d = ST_CAS;
               else if (close_pg) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase

    if (st_d != st_q)      cnt_d = '0;
    else if (cnt_q != '1)  cnt_d = cnt_q + 1'b1;
    else                   cnt_d = cnt_q;

    if (st_q == ST_IDLE)   age_d = '0;
    else if (age_q != '1)  age_d = age_q + 1'b1;
    else                   age_d = age_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '1;  // treat reset as fully precharged
      age_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      age_q <= age_d;
    end
  end

  assign st_o = st_q;

  a_r10_page_age: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE) |-> (int'(age_q) < PAGE_C));

  a_r8_ras_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && $past(st_q) == ST_OPEN) |-> (int'($past(age_q)) >= RAS_C - 1));

  a_r8_precharge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RCD && $past(st_q) == ST_IDLE) |-> (int'($past(cnt_q)) >= RP_C - 1));

endmodule

// File: rtl/dram_fpm_pins.sv
module dram_fpm_pins
  import dram_fpm_pkg::*;
#(
  parameter int AW     = 11,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  fpm_st_e          st_i,
  input  logic             rank_i,
  input  logic [AW-1:0]    row_i,
  input  logic [AW-1:0]    col_i,
  input  logic             wr_i,
  input  logic [LANES-1:0] lane_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             sample_i,
  input  logic [DW-1:0]    dq_i,
  output logic [AW-1:0]    addr_o,
  output logic [3:0]       ras_no,
  output logic [LANES-1:0] cas_no,
  output logic             we_no,
  output logic [DW-1:0]    dq_o,
  output logic             dq_oe_o,
  output logic             rd_valid_o,
  output logic [DW-1:0]    rd_data_o
);

  logic          ras_act;
  logic [DW-1:0] rd_mask;

  assign ras_act = st_i != ST_IDLE;
  assign addr_o  = (st_i == ST_CAS || st_i == ST_OPEN) ? col_i : row_i;
  assign we_no   = !(wr_i && ras_act);  // W held low through RCD: early write
  assign dq_oe_o = wr_i && st_i == ST_CAS;
  assign dq_o    = wdata_i;

  // ras_no[2*half + rank]
  for (genvar h = 0; h < 2; h++) begin : g_half
    for (genvar r = 0; r < 2; r++) begin : g_rank
      assign ras_no[2*h+r] = !(ras_act && rank_i == 1'(r));
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign cas_no[l] = !(st_i == ST_CAS && lane_i[l]);
    assign rd_mask[l*LANE_W +: LANE_W] = {LANE_W{lane_i[l]}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= sample_i;
      if (sample_i) rd_data_o <= dq_i & rd_mask;
    end
  end

  a_r6_rd_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o);

  a_r2_rank_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(~ras_no) == 0) || ($countones(~ras_no) == 2 && ras_no[0] == ras_no[2]));

endmodule

// File: rtl/dram_fpm_seq.sv
module dram_fpm_seq
  import dram_fpm_pkg::*;
#(
  parameter int AW           = 11,
  parameter int LANES        = 4,
  parameter int LANE_W       = 9,
  parameter int CLK_NS       = 20,
  parameter int T_RC_NS      = 110,
  parameter int T_RP_NS      = 40,
  parameter int T_RAS_NS     = 60,
  parameter int T_CAS_NS     = 15,
  parameter int T_CP_NS      = 10,
  parameter int T_PC_NS      = 40,
  parameter int T_RCD_NS     = 20,
  parameter int T_CWL_NS     = 15,
  parameter int T_CAC_NS     = 15,
  parameter int T_RAC_NS     = 60,
  parameter int T_PAGE_NS    = 100000,
  localparam int DW          = LANES * LANE_W,
  localparam int ADDR_W      = 2 * AW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LANES-1:0]  req_lane_i,
  input  logic [DW-1:0]     req_wdata_i,
  output logic              rd_valid_o,
  output logic [DW-1:0]     rd_data_o,
  input  logic              refresh_i,
  output logic              refresh_gnt_o,
  output logic [AW-1:0]     dram_addr_o,
  output logic [3:0]        dram_ras_no,
  output logic [LANES-1:0]  dram_cas_no,
  output logic              dram_we_no,
  output logic [DW-1:0]     dram_dq_o,
  output logic              dram_dq_oe_o,
  input  logic [DW-1:0]     dram_dq_i
);

  localparam int RAS_C    = cdiv(T_RAS_NS, CLK_NS);
  localparam int RP_EFF   = imax(cdiv(T_RP_NS, CLK_NS), cdiv(T_RC_NS, CLK_NS) - RAS_C);
  localparam int CAS_C    = cdiv(T_CAS_NS, CLK_NS);
  localparam int CAS_WR_C = imax(CAS_C, cdiv(T_CWL_NS, CLK_NS));
  localparam int CAS_RD_C = imax(CAS_C, cdiv(T_CAC_NS, CLK_NS));
  localparam int CP_EFF   = imax(cdiv(T_CP_NS, CLK_NS), cdiv(T_PC_NS, CLK_NS) - CAS_C);
  localparam int RCD_C    = cdiv(T_RCD_NS, CLK_NS);
  localparam int RAC_C    = cdiv(T_RAC_NS, CLK_NS);
  localparam int PAGE_C   = T_PAGE_NS / CLK_NS;
  localparam int CAS_WC   = imax(imax(CAS_WR_C, CAS_RD_C), RAC_C);
  localparam int AGE_LIM  = PAGE_C - CAS_WC - CP_EFF - 2;

  fpm_st_e          st;
  logic             accept, sample, hit;
  logic             cur_wr_q, open_rank_q;
  logic [AW-1:0]    open_row_q, cur_col_q;
  logic [LANES-1:0] cur_lane_q;
  logic [DW-1:0]    cur_wdata_q;

  assign hit = req_addr_i[ADDR_W-1] == open_rank_q && req_addr_i[AW +: AW] == open_row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_wr_q    <= 1'b0;
      open_rank_q <= 1'b0;
      open_row_q  <= '0;
      cur_col_q   <= '0;
      cur_lane_q  <= '0;
      cur_wdata_q <= '0;
    end else if (accept) begin
      cur_wr_q    <= req_write_i;
      open_rank_q <= req_addr_i[ADDR_W-1];
      open_row_q  <= req_addr_i[AW +: AW];
      cur_col_q   <= req_addr_i[AW-1:0];
      cur_lane_q  <= req_lane_i;
      cur_wdata_q <= req_wdata_i;
    end
  end

  dram_fpm_ctrl #(
    .RP_C(RP_EFF), .RCD_C(RCD_C), .CAS_WR_C(CAS_WR_C), .CAS_RD_C(CAS_RD_C),
    .RAC_C(RAC_C), .RAS_C(RAS_C), .CP_C(CP_EFF), .PAGE_C(PAGE_C), .AGE_LIM(AGE_LIM)
  ) i_ctrl (
    .clk_i, .rst_ni, .req_valid_i, .req_hit_i(hit), .refresh_i, .cur_wr_i(cur_wr_q),
    .ready_o(req_ready_o), .accept_o(accept), .sample_o(sample), .gnt_o(refresh_gnt_o),
    .st_o(st)
  );

  dram_fpm_pins #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) i_pins (
    .clk_i, .rst_ni, .st_i(st), .rank_i(open_rank_q), .row_i(open_row_q),
    .col_i(cur_col_q), .wr_i(cur_wr_q), .lane_i(cur_lane_q), .wdata_i(cur_wdata_q),
    .sample_i(sample), .dq_i(dram_dq_i), .addr_o(dram_addr_o), .ras_no(dram_ras_no),
    .cas_no(dram_cas_no), .we_no(dram_we_no), .dq_o(dram_dq_o), .dq_oe_o(dram_dq_oe_o),
    .rd_valid_o, .rd_data_o
  );

  a_r9_grant_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_gnt_o |-> (&dram_ras_no));

  a_r7_hit_stays_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_OPEN && accept) |=> (st == ST_CAS && !(&dram_ras_no)));

endmodule

// File: tb/test_dram_fpm_seq.sv
module test_dram_fpm_seq;

  localparam int CLK     = 20;
  localparam int RP_C    = (40 + CLK - 1) / CLK;
  localparam int RC_C    = (110 + CLK - 1) / CLK;
  localparam int RAS_C   = (60 + CLK - 1) / CLK;
  localparam int CAS_C   = (15 + CLK - 1) / CLK;
  localparam int CP_C    = (10 + CLK - 1) / CLK;
  localparam int PC_C    = (40 + CLK - 1) / CLK;
  localparam int RCD_MIN = (20 + CLK - 1) / CLK;
  localparam int RCD_MAX = 45 / CLK;
  localparam int CWL_C   = (15 + CLK - 1) / CLK;
  localparam int CAC_C   = (15 + CLK - 1) / CLK;
  localparam int RAC_C   = (60 + CLK - 1) / CLK;
  localparam int PAGE_NS = 1200;
  localparam int PAGE_C  = PAGE_NS / CLK;

  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, req_write = 0, refresh = 0;
  logic [22:0] req_addr = '0;
  logic [3:0]  req_lane = '0;
  logic [35:0] req_wdata = '0, dq_in = '0;
  logic        req_ready, rd_valid, refresh_gnt, we_n, dq_oe;
  logic [35:0] rd_data, dq_out;
  logic [10:0] dram_addr;
  logic [3:0]  ras_n, cas_n;

  dram_fpm_seq #(.T_PAGE_NS(PAGE_NS)) i_dram_fpm_seq (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_addr_i(req_addr), .req_lane_i(req_lane),
    .req_wdata_i(req_wdata), .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .refresh_i(refresh), .refresh_gnt_o(refresh_gnt), .dram_addr_o(dram_addr),
    .dram_ras_no(ras_n), .dram_cas_no(cas_n), .dram_we_no(we_n), .dram_dq_o(dq_out),
    .dram_dq_oe_o(dq_oe), .dram_dq_i(dq_in)
  );

  always #(CLK/2) clk = ~clk;

  typedef struct { bit wr; bit [22:0] addr; bit [3:0] lane; } req_t;
  req_t       accq[$];
  req_t       cur;
  bit [35:0]  expq[$];
  bit [35:0]  mem[int];
  int total = 0, bad = 0, cyc = 0, ras_falls = 0;
  int ras_fall_c = -100, ras_rise_c = -100, cas_fall_c = -100, cas_rise_c = -100;
  bit prev_ras_low = 0, prev_cas_low = 0, prev_rdv = 0, first_cas = 0, done = 0;
  bit open_rank = 0;
  logic [10:0] open_row = '0, prev_addr = '0;
  logic [3:0]  prev_cas_n = '1;
  logic        prev_we = 1;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic bit [35:0] rd_mem(input bit [22:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 36'h0;
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  // behavioural memory + protocol monitor, sampled away from the active edge
  always @(negedge clk) begin
    #1;
    if (rst_n) begin : mon
      bit ras_low, cas_low;
      ras_low = ras_n != 4'hF;
      cas_low = cas_n != 4'hF;
      if (ras_low && !prev_ras_low) begin
        ras_falls++;
        chk(ras_n == 4'b1010 || ras_n == 4'b0101, "R2 rank pair", ras_n, 4'b1010);
        chk(accq.size() > 0, "R8 activation without request", 0, 1);
        if (accq.size() > 0) begin
          chk((ras_n == 4'b0101) == accq[0].addr[22], "R2 rank select", ras_n, accq[0].addr[22]);
          chk(dram_addr == accq[0].addr[21:11], "R4 row address", dram_addr, accq[0].addr[21:11]);
        end
        chk(cyc - ras_rise_c >= RP_C, "R8 precharge", cyc - ras_rise_c, RP_C);
        chk(cyc - ras_fall_c >= RC_C, "R8 random cycle", cyc - ras_fall_c, RC_C);
        ras_fall_c = cyc; first_cas = 1;
        open_rank = (ras_n == 4'b0101); open_row = dram_addr;
      end
      if (!ras_low && prev_ras_low) begin
        chk(cyc - ras_fall_c >= RAS_C, "R8 row low min", cyc - ras_fall_c, RAS_C);
        chk(cyc - ras_fall_c <= PAGE_C, "R10 page limit", cyc - ras_fall_c, PAGE_C);
        chk(!cas_low, "R8 column high at close", cas_n, 4'hF);
        ras_rise_c = cyc;
      end
      if (cas_low && !prev_cas_low) begin
        chk(ras_low, "R7 column with row open", ras_n, 0);
        chk(accq.size() > 0, "R3 column without request", 0, 1);
        if (accq.size() > 0) begin
          cur = accq.pop_front();
          chk(~cas_n == cur.lane, "R3 lane strobes", ~cas_n, cur.lane);
          chk(dram_addr == cur.addr[10:0], "R4 column address", dram_addr, cur.addr[10:0]);
          chk(open_rank == cur.addr[22] && open_row == cur.addr[21:11], "R7 open page match",
              {open_rank, open_row}, cur.addr[22:11]);
          if (first_cas) begin
            chk(cyc - ras_fall_c >= RCD_MIN && cyc - ras_fall_c <= RCD_MAX, "R11 row to column",
                cyc - ras_fall_c, RCD_MIN);
            first_cas = 0;
          end else begin
            chk(cyc - cas_rise_c >= CP_C, "R7 column precharge", cyc - cas_rise_c, CP_C);
            chk(cyc - cas_fall_c >= PC_C, "R7 page cycle", cyc - cas_fall_c, PC_C);
          end
          cas_fall_c = cyc;
          if (cur.wr) begin
            bit [35:0] w;
            chk(!we_n && dq_oe, "R5 early write strobes", {we_n, dq_oe}, 2'b01);
            w = rd_mem(cur.addr);
            for (int l = 0; l < 4; l++) if (cur.lane[l]) w[9*l +: 9] = dq_out[9*l +: 9];
            mem[int'(cur.addr)] = w;
          end else begin
            bit [35:0] e, m;
            chk(we_n && !dq_oe, "R5 read strobes", {we_n, dq_oe}, 2'b10);
            m = rd_mem(cur.addr); e = '0;
            for (int l = 0; l < 4; l++) if (cur.lane[l]) e[9*l +: 9] = m[9*l +: 9];
            expq.push_back(e);
          end
        end
      end
      if (cas_low && prev_cas_low) begin
        chk(cas_n == prev_cas_n && dram_addr == prev_addr && we_n == prev_we,
            "R4 column phase stable", {cas_n, dram_addr, we_n}, {prev_cas_n, prev_addr, prev_we});
      end
      if (!cas_low && prev_cas_low) begin
        chk(cyc - cas_fall_c >= CAS_C, "R12 column low min", cyc - cas_fall_c, CAS_C);
        if (cur.wr) chk(cyc - cas_fall_c >= CWL_C, "R5 write setup to column rise",
                        cyc - cas_fall_c, CWL_C);
        cas_rise_c = cyc;
      end
      if (rd_valid) begin
        chk(!prev_rdv, "R6 single pulse", prev_rdv, 0);
        chk(expq.size() > 0, "R6 unexpected read data", 0, 1);
        if (expq.size() > 0) begin
          bit [35:0] e;
          e = expq.pop_front();
          chk(rd_data == e, "R6 read data", rd_data, e);
        end
      end
      if (refresh) chk(!req_ready, "R9 no accept during refresh", req_ready, 0);
      if (refresh_gnt) chk(!ras_low && cyc - ras_rise_c >= RP_C, "R9 grant when closed",
                           ras_n, 4'hF);
      // memory drives valid data only once both access times have elapsed
      dq_in = '0;
      if (cas_low && we_n) begin
        bit [35:0] m;
        m = rd_mem(cur.addr);
        for (int l = 0; l < 4; l++) begin
          if (!cas_n[l] && cyc - cas_fall_c + 1 >= CAC_C && cyc - ras_fall_c + 1 >= RAC_C)
            dq_in[9*l +: 9] = m[9*l +: 9];
          else if (!cas_n[l]) dq_in[9*l +: 9] = 9'h155;
          else dq_in[9*l +: 9] = 9'h0AA;
        end
      end
      if (req_valid && req_ready)
        accq.push_back('{wr: req_write, addr: req_addr, lane: req_lane});
      prev_ras_low = ras_low; prev_cas_low = cas_low; prev_rdv = rd_valid;
      prev_cas_n = cas_n; prev_addr = dram_addr; prev_we = we_n;
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic req(input bit wr, input bit rank, input int row, input int col,
                     input bit [3:0] lane, input bit [35:0] data);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = {rank, 11'(row), 11'(col)};
    req_lane = lane; req_wdata = data;
    forever begin
      #2;
      if (req_ready) break;
      @(negedge clk);
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK * 150000);
    chk(0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    int n0;
    settle(3);
    #2;
    // R1 reset state
    chk(ras_n == 4'hF && cas_n == 4'hF, "R1 strobes high", {ras_n, cas_n}, 8'hFF);
    chk(we_n && !dq_oe && !rd_valid && !refresh_gnt, "R1 controls idle",
        {we_n, dq_oe, rd_valid, refresh_gnt}, 4'b1000);
    rst_n = 1;
    #2;
    chk(req_ready, "R1 ready after reset", req_ready, 1);

    // R7: write then read hit on same page
    req(1, 0, 5, 3, 4'hF, 36'h1_2345_6789);
    settle(6);
    n0 = ras_falls;
    req(0, 0, 5, 3, 4'hF, 0);
    settle(6);
    chk(ras_falls == n0, "R7 hit keeps page open", ras_falls, n0);

    // R3: partial write keeps other lanes, masked read
    req(1, 0, 5, 3, 4'b0101, 36'hF_FFFF_FFFF);
    req(0, 0, 5, 3, 4'hF, 0);
    req(0, 0, 5, 3, 4'b1000, 0);

    // R2: other rank, same row/col
    req(1, 1, 5, 3, 4'hF, 36'hA_5A5A_5A5A);
    req(0, 1, 5, 3, 4'hF, 0);
    req(0, 0, 5, 3, 4'b0011, 0);

    // R8 misses across rows, R4 corner addresses
    req(1, 0, 7, 0, 4'hF, 36'h0_0000_0001);
    req(1, 0, 8, 1, 4'hF, 36'h8_0000_0000);
    req(1, 1, 2047, 2047, 4'hF, 36'h5_5555_5555);
    req(0, 0, 7, 0, 4'hF, 0);
    req(0, 1, 2047, 2047, 4'b0110, 0);
    req(0, 0, 8, 1, 4'hF, 0);
    settle(8);

    // R10: long hit stream must be broken by the page limit
    n0 = ras_falls;
    for (int i = 0; i < 40; i++) req(1, 0, 9, i, 4'hF, 36'(i * 36'h1_0101_0101));
    for (int i = 0; i < 40; i++) req(0, 0, 9, i, 4'hF, 0);
    chk(ras_falls >= n0 + 3, "R10 page reopened", ras_falls, n0 + 3);

    // R9: refresh closes the page and blocks requests
    req(0, 0, 9, 5, 4'hF, 0);
    settle(4);
    n0 = ras_falls;
    @(negedge clk);
    refresh = 1;
    begin
      bit got = 0;
      for (int i = 0; i < 100; i++) begin
        @(negedge clk); #2;
        if (refresh_gnt) begin got = 1; break; end
      end
      chk(got, "R9 grant arrives", got, 1);
    end
    settle(3);
    @(negedge clk);
    refresh = 0;
    req(0, 0, 9, 5, 4'hF, 0);
    settle(6);
    chk(ras_falls == n0 + 1, "R9 page reopened after refresh", ras_falls, n0 + 1);

    settle(20);
    chk(expq.size() == 0 && accq.size() == 0, "R6 all reads returned",
        expq.size() + accq.size(), 0);
    finish_run();
  end

endmodule